// File: doc/BRIEF.md
# Protected interrupt status controller

This block collects single-cycle or level event lines from many hardware sources into one sticky status bit per source. It drives two interrupt outputs. The maskable output `irq_o` follows status bits that are both enabled and routed to it. The non-maskable output `nmi_o` follows status bits routed to it, whatever the enable mask says. The raw event lines are also passed straight out on `ev_raw_o`, so a system interrupt controller elsewhere can take them without using the local status logic.

Software reaches the block through a simple register bus with a privilege sideband bit. Through this bus it can:
- read the status;
- force status bits to 1 with a write-one preset;
- drop status bits with a write-one clear;
- program the enable mask, the two routing vectors and a per-source protection vector.

A protected source accepts preset and clear only from privileged accesses. The enable, routing and protection vectors accept writes only from privileged accesses. A rejected write completes quietly and changes nothing. One source index is reserved and behaves as a constant zero.

Top module: `prot_intc`

## Requirements
- R1: After reset every register reads 0, and `irq_o` and `nmi_o` are 0.
- R2: An event input at 1 on a clock edge sets that source's status bit. The bit stays 1 after the event drops, until it is cleared.
- R3: A write of 1s to the preset register (kind 2) sets the matching status bits. A read of the preset register returns 0.
- R4: A write of 1s to the clear register (kind 3) resets the matching status bits. It reads back 0. If an event arrives in the same cycle as a clear of the same bit, that bit ends up set.
- R5: `irq_o` is 1 exactly when some source has status, enable and IRQ route (kind 4) all at 1.
- R6: `nmi_o` is 1 exactly when some source has status and NMI route (kind 5) both at 1. The enable mask has no effect on it.
- R7: `ev_raw_o` equals `ev_in`, with the reserved index forced to 0, in the same cycle and without any masking.
- R8: For a source whose protection bit (kind 6) is 1, preset and clear writes with `bus_priv`=0 leave its status unchanged. The same writes with `bus_priv`=1 take effect.
- R9: Writes to enable (kind 0), IRQ route, NMI route and protection change those registers only when `bus_priv`=1. A write to status (kind 1) changes nothing.
- R10: Index 35 is reserved. It has no event input, and its bit reads 0 in every register even after a preset. Bits at index 49 and above read 0.
- R11: Register address: `bus_addr[3:1]` selects the kind. `bus_addr[0]` selects the word: word 0 holds sources 0–31 in bits 31:0, and word 1 holds sources 32–48 in bits 16:0. Kind 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 4 | Register kind and word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ev_in | input | 49 | Hardware event inputs |
| ev_raw_o | output | 49 | Unmasked event triggers to an external controller |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
The random phase drives sparse event vectors against random register writes, with a random privilege bit on each write. This separates correct status stickiness and routing from designs that drop the mask, merge the two routes, or ignore privilege. Directed cases isolate the orderings that random traffic rarely hits:
- an event and a clear landing on the same bit in the same cycle, which shows whether the event wins;
- a user clear of a protected bit, compared with a privileged clear of the same bit;
- an NMI raised with the enable mask at 0, which shows that the NMI path ignores the mask;
- a preset aimed at the reserved index, which shows that the index stays at 0.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    typedef enum logic [2:0] {
        RK_ENABLE = 3'd0,
        RK_STATUS = 3'd1,
        RK_PRESET = 3'd2,
        RK_CLEAR  = 3'd3,
        RK_IRQRT  = 3'd4,
        RK_NMIRT  = 3'd5,
        RK_PROT   = 3'd6,
        RK_NONE   = 3'd7
    } reg_kind_e;

    localparam int NCFG = 4;

    function automatic reg_kind_e cfg_kind(input int k);
        case (k)
            0:       return RK_ENABLE;
            1:       return RK_IRQRT;
            2:       return RK_NMIRT;
            default: return RK_PROT;
        endcase
    endfunction
endpackage

// File: rtl/intc_cfg_reg.sv
`timescale 1ns/1ps
module intc_cfg_reg #(
    parameter int PW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] lane,
    input  logic [PW-1:0] wbits,
    output logic [PW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~lane) | (wbits & lane);
        end
    end
endmodule

// File: rtl/intc_status.sv
`timescale 1ns/1ps
module intc_status #(
    parameter int PW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ev,
    input  logic [PW-1:0] pre_bits,
    input  logic [PW-1:0] clr_bits,
    output logic [PW-1:0] st
);
    // new set sources are ORed after the clear, so an event beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st <= (st & ~clr_bits) | ev | pre_bits;
        end
    end
endmodule

// File: rtl/intc_route.sv
`timescale 1ns/1ps
module intc_route #(
    parameter int PW = 64
) (
    input  logic [PW-1:0] st,
    input  logic [PW-1:0] en,
    input  logic [PW-1:0] irt,
    input  logic [PW-1:0] nrt,
    output logic          irq,
    output logic          nmi
);
    always_comb begin
        irq = |(st & en & irt);
        nmi = |(st & nrt);
    end
endmodule

// File: rtl/prot_intc.sv
`timescale 1ns/1ps
module prot_intc
    import intc_pkg::*;
#(
    parameter  int N_SRC    = 49,
    parameter  int RSVD_IDX = 35,
    localparam int NW       = (N_SRC + 31) / 32,
    localparam int WB       = (NW > 1) ? $clog2(NW) : 1,
    localparam int AW       = WB + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_priv,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_SRC-1:0] ev_in,
    output logic [N_SRC-1:0] ev_raw_o,
    output logic             irq_o,
    output logic             nmi_o
);
    localparam int PW = NW * 32;

    function automatic logic [PW-1:0] valid_mask(input int dummy);
        logic [PW-1:0] m;
        m = '0;
        for (int i = 0; i < PW; i++) begin
            m[i] = (i < N_SRC) && (i != RSVD_IDX) && (dummy == 0);
        end
        return m;
    endfunction

    localparam logic [PW-1:0] VALID = valid_mask(0);

    reg_kind_e     kind;
    logic [WB-1:0] widx;
    logic          wr_go;
    logic [PW-1:0] lane;
    logic [PW-1:0] wbits;
    logic [PW-1:0] ev_pad;
    logic [PW-1:0] user_ok;
    logic [PW-1:0] pre_bits;
    logic [PW-1:0] clr_bits;
    logic [PW-1:0] st_q;
    logic [PW-1:0] cfg_q [NCFG];
    logic [PW-1:0] cfg_en, cfg_irt, cfg_nrt, cfg_prot;
    logic [PW-1:0] rd_vec;

    assign kind  = reg_kind_e'(bus_addr[AW-1:WB]);
    assign widx  = bus_addr[WB-1:0];
    assign wr_go = bus_sel && bus_wr;

    // place the write word into its lane of the wide vector
    always_comb begin
        lane  = '0;
        wbits = '0;
        for (int w = 0; w < NW; w++) begin
            if (int'(widx) == w) begin
                lane[w*32 +: 32]  = '1;
                wbits[w*32 +: 32] = bus_wdata;
            end
        end
        lane  = lane & VALID;
        wbits = wbits & VALID;
    end

    always_comb begin
        ev_pad = '0;
        ev_pad[N_SRC-1:0] = ev_in;
        ev_pad = ev_pad & VALID;
    end
    assign ev_raw_o = ev_pad[N_SRC-1:0];

    assign cfg_en   = cfg_q[0];
    assign cfg_irt  = cfg_q[1];
    assign cfg_nrt  = cfg_q[2];
    assign cfg_prot = cfg_q[3];

    assign user_ok  = ~cfg_prot | {PW{bus_priv}};
    assign pre_bits = (wr_go && kind == RK_PRESET) ? (wbits & user_ok) : '0;
    assign clr_bits = (wr_go && kind == RK_CLEAR)  ? (wbits & user_ok) : '0;

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        intc_cfg_reg #(.PW(PW)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_go && bus_priv && kind == cfg_kind(k)),
            .lane  (lane),
            .wbits (wbits),
            .q     (cfg_q[k])
        );
    end

    intc_status #(.PW(PW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_pad),
        .pre_bits (pre_bits),
        .clr_bits (clr_bits),
        .st       (st_q)
    );

    intc_route #(.PW(PW)) u_route (
        .st  (st_q),
        .en  (cfg_en),
        .irt (cfg_irt),
        .nrt (cfg_nrt),
        .irq (irq_o),
        .nmi (nmi_o)
    );

    always_comb begin
        unique case (kind)
            RK_ENABLE: rd_vec = cfg_en;
            RK_STATUS: rd_vec = st_q;
            RK_IRQRT:  rd_vec = cfg_irt;
            RK_NMIRT:  rd_vec = cfg_nrt;
            RK_PROT:   rd_vec = cfg_prot;
            default:   rd_vec = '0;
        endcase
        bus_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (int'(widx) == w) bus_rdata = rd_vec[w*32 +: 32];
        end
    end
endmodule

// File: rtl/prot_intc_chk.sv
`timescale 1ns/1ps
module prot_intc_chk #(
    parameter int N_SRC    = 49,
    parameter int RSVD_IDX = 35,
    parameter int AW       = 4,
    parameter int WB       = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_priv,
    input logic [AW-1:0]    bus_addr,
    input logic [N_SRC-1:0] ev_raw_o,
    input logic             irq_o,
    input logic             nmi_o,
    input logic [N_SRC-1:0] st,
    input logic [N_SRC-1:0] en,
    input logic [N_SRC-1:0] irt,
    input logic [N_SRC-1:0] nrt,
    input logic [N_SRC-1:0] prot
);
    logic user_wr;
    logic [2:0] kind;
    assign user_wr = bus_sel && bus_wr && !bus_priv;
    assign kind    = bus_addr[AW-1:WB];

    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_raw_o) |=> ((st & $past(ev_raw_o)) == $past(ev_raw_o)));

    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(st & en & irt)));

    a_r6_nmi_ignores_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st & nrt)) |-> nmi_o);

    a_r8_protected_user_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (user_wr && kind == 3'd3) |=> ((st & $past(prot & st)) == $past(prot & st)));

    a_r9_user_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        user_wr |=> ($stable(en) && $stable(irt) && $stable(nrt) && $stable(prot)));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !st[RSVD_IDX] && !ev_raw_o[RSVD_IDX]);
endmodule

bind prot_intc prot_intc_chk #(
    .N_SRC(N_SRC), .RSVD_IDX(RSVD_IDX), .AW(AW), .WB(WB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_priv (bus_priv),
    .bus_addr (bus_addr),
    .ev_raw_o (ev_raw_o),
    .irq_o    (irq_o),
    .nmi_o    (nmi_o),
    .st       (st_q[N_SRC-1:0]),
    .en       (cfg_en[N_SRC-1:0]),
    .irt      (cfg_irt[N_SRC-1:0]),
    .nrt      (cfg_nrt[N_SRC-1:0]),
    .prot     (cfg_prot[N_SRC-1:0])
);

// File: tb/prot_intc_bench.sv
`timescale 1ns/1ps
module prot_intc_bench;
    localparam logic [63:0] VM = ((64'd1 << 49) - 64'd1) & ~(64'd1 << 35);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [48:0] ev_in = '0;
    logic [48:0] ev_raw_o;
    logic        irq_o, nmi_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] m_en = '0, m_irt = '0, m_nrt = '0, m_prot = '0, m_st = '0;

    always #10 clk = ~clk;

    prot_intc u_prot_intc (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ev_in(ev_in), .ev_raw_o(ev_raw_o),
        .irq_o(irq_o), .nmi_o(nmi_o)
    );

    function automatic logic [63:0] place(input logic [31:0] d, input bit w);
        return w ? {d, 32'd0} : {32'd0, d};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        logic [63:0] v;
        case (a[3:1])
            3'd0: v = m_en;
            3'd1: v = m_st;
            3'd4: v = m_irt;
            3'd5: v = m_nrt;
            3'd6: v = m_prot;
            default: v = '0;
        endcase
        return a[0] ? v[63:32] : v[31:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check({tag, " R5 irq"}, {63'd0, irq_o}, {63'd0, |(m_st & m_en & m_irt)});
        check({tag, " R6 nmi"}, {63'd0, nmi_o}, {63'd0, |(m_st & m_nrt)});
    endtask

    // one bus cycle (write when wr=1, idle otherwise) plus events, then model update
    task automatic op(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      input bit pv, input logic [63:0] ev);
        logic [63:0] wb, ok, pre, clr;
        @(negedge clk);
        bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_priv = pv;
        ev_in = ev[48:0];
        #1 check("R7 raw", {15'd0, ev_raw_o}, ev & VM);
        @(posedge clk);
        wb  = place(d, a[0]) & VM;
        ok  = ~m_prot | {64{pv}};
        pre = (wr && a[3:1] == 3'd2) ? (wb & ok) : '0;
        clr = (wr && a[3:1] == 3'd3) ? (wb & ok) : '0;
        m_st = (m_st & ~clr) | (ev & VM) | pre;
        if (wr && pv) begin
            case (a[3:1])
                3'd0: m_en   = (m_en   & ~place('1, a[0])) | wb;
                3'd4: m_irt  = (m_irt  & ~place('1, a[0])) | wb;
                3'd5: m_nrt  = (m_nrt  & ~place('1, a[0])) | wb;
                3'd6: m_prot = (m_prot & ~place('1, a[0])) | wb;
                default: ;
            endcase
        end
        #1 check_outs("op");
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; ev_in = '0;
        #1 check(tag, {32'd0, bus_rdata}, {32'd0, exp_rd(a)});
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 16; a++) rd(4'(a), {tag, " R11 readback"});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] ev;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_all("R1");
        check_outs("R1");

        // R2 sticky event on bit 3, R5 irq after enable+route
        op(1, 4'h0, 32'h8, 1, '0);          // privileged enable bit 3
        op(1, 4'h8, 32'h8, 1, '0);          // privileged irq route bit 3
        op(0, 4'h0, 0, 0, 64'h8);
        op(0, 4'h0, 0, 0, '0);
        rd(4'h2, "R2 sticky status");
        check("R5 irq set", {63'd0, irq_o}, 64'd1);
        // R4 event and clear in same cycle: event wins
        op(1, 4'h6, 32'h8, 1, 64'h8);
        rd(4'h2, "R4 event beats clear");
        op(1, 4'h6, 32'h8, 1, '0);
        rd(4'h2, "R4 clear");
        rd(4'h6, "R4 clear reads 0");
        // R3 preset, reads 0
        op(1, 4'h4, 32'h10, 0, '0);
        rd(4'h2, "R3 preset");
        rd(4'h4, "R3 preset reads 0");
        // R6 nmi ignores enable (bit 4 not enabled)
        op(1, 4'hA, 32'h10, 1, '0);
        check("R6 nmi without enable", {63'd0, nmi_o}, 64'd1);
        // R8 protect bit 4, user clear ignored, privileged clear works
        op(1, 4'hC, 32'h10, 1, '0);
        op(1, 4'h6, 32'h10, 0, '0);
        rd(4'h2, "R8 user clear ignored");
        op(1, 4'h6, 32'h10, 1, '0);
        rd(4'h2, "R8 privileged clear");
        // R9 user enable write ignored, status write ignored
        op(1, 4'h0, 32'hFFFF_FFFF, 0, '0);
        rd(4'h0, "R9 user enable ignored");
        op(1, 4'h2, 32'hFFFF_FFFF, 1, '0);
        rd(4'h2, "R9 status write ignored");
        // R10 reserved bit 35 (word 1 bit 3) and high bits
        op(1, 4'h5, 32'hFFFF_FFFF, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(4'h3, "R10 reserved status");
        check("R10 reserved bit", {63'd0, bus_rdata[3]}, 64'd0);
        rd(4'h1, "R10 enable high word");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            ev = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
               & {$urandom, $urandom};
            a = 4'($urandom_range(0, 15));
            op($urandom_range(0, 3) != 0, a, $urandom, $urandom_range(0, 1) == 1, ev);
            if (i % 200 == 199) rd_all("rand R2 R8 R9");
        end
        rd_all("final");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule